// File: doc/BRIEF.md
# Timed PCM Sample Fetch Engine

This block plays a buffer of 8-bit samples at a fixed rate. Software programs three values: a start address, a length and a control word. When the enable bit is set, an internal cycle timer counts down. Each time the timer expires, the block either fetches the next byte through a request/valid memory port or, once the buffer is used up, raises an interrupt and stops.

Each fetched byte is shifted right by one bit. The 7-bit result goes out with a one-cycle write strobe to a downstream DAC register. The sample address advances after every response and wraps within a 15-bit space.

A status port passes through seven status bits produced elsewhere. It replaces bit 7 with the pending sample-interrupt flag.

Top module: `pcm_fetch_engine`

## Requirements
- R1: A write with `wr_sel_i`=0 (address) sets the sample address to `wr_data_i` shifted left by 6 bits. The first fetch after that write presents this address on `mem_addr_o`.
- R2: A write with `wr_sel_i`=1 (length) sets the remaining count to `wr_data_i`*16+1. That many fetches are made before the buffer counts as used up.
- R3: A write with `wr_sel_i`=2 (control) sets enable from `wr_data_i` bit 4 and clears a pending sample interrupt. When bit 4 is 1, the same write reloads the cycle timer to PERIOD (246), even if the block is already running.
- R4: While enabled, a timer expiry happens every PERIOD cycles. The first expiry comes PERIOD cycles after the enabling control write. Each expiry that finds data left raises `mem_req_o`.
- R5: An expiry that finds the count used up raises `irq_o` and clears enable. It makes no fetch, and no further fetch follows.
- R6: In the cycle after a handshake (`mem_req_o` and `mem_valid_i` both high), `dac_we_o` pulses for one cycle and `dac_data_o` equals `mem_data_i[7:1]` as it was at the handshake.
- R7: After each response the sample address increments by one. It wraps from 0x7FFF to 0x0000.
- R8: `stat_o[7]` equals the sample-interrupt flag, and `stat_o[6:0]` equals `stat_i[6:0]`.
- R9: After reset, enable, the interrupt flag, the address and the count are zero, the timer holds PERIOD, and `mem_req_o`, `dac_we_o` and `irq_o` are low.
- R10: `mem_req_o` stays high, with `mem_addr_o` unchanged, until `mem_valid_i` is seen.
- R11: A control write with bit 4 clear stops playback, and no further fetch or interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock; one timer step per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 address, 1 length, 2 control |
| wr_data_i | input | 8 | Write data |
| stat_i | input | 7 | Other status bits to pass through |
| stat_o | output | 8 | Status read value; bit 7 is the sample-interrupt flag |
| mem_req_o | output | 1 | Memory fetch request |
| mem_addr_o | output | 15 | Fetch address |
| mem_valid_i | input | 1 | Memory response valid |
| mem_data_i | input | 8 | Memory response byte |
| dac_we_o | output | 1 | DAC register write strobe |
| dac_data_o | output | 7 | Halved sample for the DAC |
| irq_o | output | 1 | Sample-interrupt request |

## Verification
The hardest case to reach is the address wrap from 0x7FFF to 0x0000. The highest programmable start address is 0x3FC0, and one run fetches at most 4081 bytes, so the wrap only shows up after several back-to-back runs of more than sixteen thousand fetches. At the default period that is far beyond any practical run length. The bench therefore adds a second instance with a two-cycle period and a zero-wait memory. It programs the top start address once, re-arms maximum-length runs until the count passes the wrap, and checks every consecutive request address. The main instance, meanwhile, uses random memory latencies and random control bits to test exact period spacing and data halving.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int unsigned PCM_ADDR_W     = 15;
  localparam int unsigned PCM_DATA_W     = 8;
  localparam int unsigned PCM_ADDR_SHIFT = 6;
  localparam int unsigned PCM_LEN_SHIFT  = 4;
  localparam int unsigned PCM_PERIOD     = 246;
  localparam int unsigned PCM_EN_BIT     = 4;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } pcm_sel_e;
endpackage

// File: rtl/pcm_rate_timer.sv
module pcm_rate_timer #(
  parameter int unsigned PERIOD = 246
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_i,
  input  logic reload_i,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(PERIOD + 1);
  localparam logic [TW-1:0] RELOAD = TW'(PERIOD);
  localparam logic [TW-1:0] LAST   = TW'(1);

  logic [TW-1:0] tmr_q;

  assign tick_o = run_i && !hold_i && (tmr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= RELOAD;
    else if (reload_i)          tmr_q <= RELOAD;
    else if (run_i && !hold_i)  tmr_q <= (tmr_q == LAST) ? RELOAD : tmr_q - LAST;
  end

  a_r4_timer_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q >= LAST) && (tmr_q <= RELOAD));
endmodule

// File: rtl/pcm_cursor.sv
module pcm_cursor #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DW         = 8,
  parameter int unsigned ADDR_SHIFT = 6,
  parameter int unsigned LEN_SHIFT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              len_wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              tick_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_o,
  output logic              empty_o
);
  localparam int unsigned CNT_W = DW + LEN_SHIFT + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              has_data;
  logic [CNT_W-1:0]  len_load;
  logic [ADDR_W-1:0] addr_load;

  // count is two's complement; exhausted once it is zero or negative
  assign has_data  = !cnt_q[CNT_W-1] && (cnt_q != '0);
  assign fetch_o   = tick_i && has_data;
  assign empty_o   = tick_i && !has_data;
  assign len_load  = CNT_W'({wdata_i, {LEN_SHIFT{1'b0}}}) + ONE;
  assign addr_load = ADDR_W'({wdata_i, {ADDR_SHIFT{1'b0}}});
  assign addr_o    = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (len_wr_i) cnt_q <= len_load;
    else if (tick_i)   cnt_q <= cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_wr_i) addr_q <= addr_load;
    else if (adv_i)     addr_q <= addr_q + ADDR_W'(1);
  end
endmodule

// File: rtl/pcm_fetch_port.sv
module pcm_fetch_port #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DW-1:0]     mem_data_i,
  output logic              adv_o,
  output logic              dac_we_o,
  output logic [DW-2:0]     dac_data_o
);
  assign adv_o = mem_req_o && mem_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
    end else if (adv_o) begin
      mem_req_o  <= 1'b0;
    end else if (start_i && !mem_req_o) begin
      mem_req_o  <= 1'b1;
      mem_addr_o <= addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_we_o   <= 1'b0;
      dac_data_o <= '0;
    end else begin
      dac_we_o <= adv_o;
      if (adv_o) dac_data_o <= mem_data_i[DW-1:1];
    end
  end

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r6_dac_after_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_we_o |-> $past(mem_req_o && mem_valid_i));
endmodule

// File: rtl/pcm_fetch_engine.sv
module pcm_fetch_engine
  import pcm_pkg::*;
#(
  parameter int unsigned PERIOD     = PCM_PERIOD,
  parameter int unsigned ADDR_W     = PCM_ADDR_W,
  parameter int unsigned DW         = PCM_DATA_W,
  parameter int unsigned ADDR_SHIFT = PCM_ADDR_SHIFT,
  parameter int unsigned LEN_SHIFT  = PCM_LEN_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [DW-2:0]     stat_i,
  output logic [DW-1:0]     stat_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DW-1:0]     mem_data_i,
  output logic              dac_we_o,
  output logic [DW-2:0]     dac_data_o,
  output logic              irq_o
);
  pcm_sel_e          sel;
  logic              ctrl_wr, addr_wr, len_wr, en_bit;
  logic              enable_q, irq_q;
  logic              tick, fetch, empty, adv;
  logic [ADDR_W-1:0] cur_addr;

  assign sel     = pcm_sel_e'(wr_sel_i);
  assign ctrl_wr = wr_en_i && (sel == SEL_CTRL);
  assign addr_wr = wr_en_i && (sel == SEL_ADDR);
  assign len_wr  = wr_en_i && (sel == SEL_LEN);
  assign en_bit  = wr_data_i[PCM_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (ctrl_wr) begin
      enable_q <= en_bit;
      irq_q    <= 1'b0;
    end else if (empty) begin
      enable_q <= 1'b0;
      irq_q    <= 1'b1;
    end
  end

  pcm_rate_timer #(.PERIOD(PERIOD)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (enable_q),
    .hold_i   (ctrl_wr),
    .reload_i (ctrl_wr && en_bit),
    .tick_o   (tick)
  );

  pcm_cursor #(
    .ADDR_W(ADDR_W), .DW(DW), .ADDR_SHIFT(ADDR_SHIFT), .LEN_SHIFT(LEN_SHIFT)
  ) u_cursor (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_wr_i (addr_wr),
    .len_wr_i  (len_wr),
    .wdata_i   (wr_data_i),
    .tick_i    (tick),
    .adv_i     (adv),
    .addr_o    (cur_addr),
    .fetch_o   (fetch),
    .empty_o   (empty)
  );

  pcm_fetch_port #(.ADDR_W(ADDR_W), .DW(DW)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (fetch),
    .addr_i      (cur_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_data_i  (mem_data_i),
    .adv_o       (adv),
    .dac_we_o    (dac_we_o),
    .dac_data_o  (dac_data_o)
  );

  assign irq_o  = irq_q;
  assign stat_o = {irq_q, stat_i};

  a_r3_ctrl_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !irq_o);

  a_r5_irq_stops_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> !enable_q);

  a_r11_fetch_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(enable_q));
endmodule

// File: tb/pcm_fetch_engine_bench.sv
module pcm_fetch_engine_bench;
  import pcm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PER        = 246;
  localparam int FAST_PER   = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  // main instance
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [7:0]  wr_data = '0;
  logic [6:0]  stat_in = '0;
  logic [7:0]  stat_o;
  logic        mem_req_o, dac_we_o, irq_o;
  logic [14:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [7:0]  mem_data_i = '0;
  logic [6:0]  dac_data_o;

  pcm_fetch_engine u_pcm_fetch_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .stat_i(stat_in), .stat_o(stat_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
    .mem_data_i(mem_data_i), .dac_we_o(dac_we_o), .dac_data_o(dac_data_o),
    .irq_o(irq_o)
  );

  // fast instance for the address wrap
  logic        f_wr_en = 1'b0;
  logic [1:0]  f_wr_sel = 2'd3;
  logic [7:0]  f_wr_data = '0;
  logic [7:0]  f_stat;
  logic        f_req, f_we, f_irq;
  logic [14:0] f_addr;
  logic [7:0]  f_mdata;
  logic [6:0]  f_dac;

  assign f_mdata = mem_byte(f_addr);

  pcm_fetch_engine #(.PERIOD(FAST_PER)) u_fast (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(f_wr_en), .wr_sel_i(f_wr_sel),
    .wr_data_i(f_wr_data), .stat_i(7'h00), .stat_o(f_stat),
    .mem_req_o(f_req), .mem_addr_o(f_addr), .mem_valid_i(f_req),
    .mem_data_i(f_mdata), .dac_we_o(f_we), .dac_data_o(f_dac), .irq_o(f_irq)
  );

  function automatic logic [7:0] mem_byte(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input bit fast, input pcm_sel_e sel, input logic [7:0] d);
    @(negedge clk_i);
    if (fast) begin f_wr_en = 1'b1; f_wr_sel = sel; f_wr_data = d; end
    else      begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
    @(negedge clk_i);
    f_wr_en = 1'b0; wr_en = 1'b0;
  endtask

  // main memory model: random latency 0..2 cycles after request
  int wait_cnt = 0;
  always @(negedge clk_i) begin
    if (mem_valid_i) mem_valid_i = 1'b0;
    else if (mem_req_o) begin
      if (wait_cnt == 0) begin
        mem_valid_i = 1'b1;
        mem_data_i  = mem_byte(mem_addr_o);
        wait_cnt    = $urandom_range(0, 2);
      end else wait_cnt--;
    end
  end

  // fast instance address sequence monitor
  logic [14:0] f_prev = '0;
  bit f_have = 0, f_wrap = 0;
  int f_bad = 0, f_cnt = 0;
  always @(negedge clk_i) begin
    if (rst_ni && f_req) begin
      if (f_have) begin
        if (f_addr != 15'(f_prev + 15'd1)) f_bad++;
        if (f_prev == 15'h7FFF && f_addr == 15'h0000) f_wrap = 1;
      end
      f_have = 1;
      f_prev = f_addr;
      f_cnt++;
    end
  end

  task automatic play(input logic [7:0] ad, input logic [7:0] ln, input logic [7:0] ctl);
    int last, guard, nf;
    logic [14:0] ea;
    cpu_wr(0, SEL_ADDR, ad);
    cpu_wr(0, SEL_LEN, ln);
    cpu_wr(0, SEL_CTRL, ctl | 8'h10);
    last = cyc;
    ea = {1'b0, ad, 6'b0};
    nf = int'(ln) * 16 + 1;
    for (int i = 0; i < nf; i++) begin
      guard = 0;
      while (!mem_req_o && !irq_o && guard < 400) begin @(negedge clk_i); guard++; end
      chk(mem_req_o && !irq_o, "R2 fetch count", i, nf);
      chk(cyc - last == PER, "R4 period", cyc - last, PER);
      last = cyc;
      chk(mem_addr_o == ea, (i == 0) ? "R1 start address" : "R7 address step",
          int'(mem_addr_o), int'(ea));
      guard = 0;
      while (!dac_we_o && guard < 10) begin @(negedge clk_i); guard++; end
      chk(dac_we_o && dac_data_o == mem_byte(ea) >> 1, "R6 dac data",
          int'(dac_data_o), int'(mem_byte(ea) >> 1));
      @(negedge clk_i);
      chk(!dac_we_o, "R6 dac pulse", int'(dac_we_o), 0);
      ea = ea + 15'd1;
    end
    guard = 0;
    while (!irq_o && !mem_req_o && guard < 400) begin @(negedge clk_i); guard++; end
    chk(irq_o && !mem_req_o, "R5 irq on exhaust", int'(irq_o), 1);
    chk(cyc - last == PER, "R5 irq timing", cyc - last, PER);
    stat_in = 7'($urandom);
    #1;
    chk(stat_o == {1'b1, stat_in}, "R8 status with flag", int'(stat_o), int'({1'b1, stat_in}));
    begin
      bit seen = 0;
      repeat (300) begin @(negedge clk_i); if (mem_req_o) seen = 1; end
      chk(!seen, "R5 no fetch after exhaust", int'(seen), 0);
    end
    cpu_wr(0, SEL_CTRL, 8'h00);
    chk(!irq_o && !stat_o[7], "R3 control write clears irq", int'(stat_o[7]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int guard, last;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    chk(!mem_req_o && !dac_we_o && !irq_o, "R9 reset outputs",
        int'({mem_req_o, dac_we_o, irq_o}), 0);
    chk(stat_o[7] == 1'b0, "R9 reset flag", int'(stat_o[7]), 0);
    begin
      bit seen = 0;
      cpu_wr(0, SEL_LEN, 8'h03);
      repeat (300) begin @(negedge clk_i); if (mem_req_o || irq_o) seen = 1; end
      chk(!seen, "R9 idle while disabled", int'(seen), 0);
    end

    // R8 passthrough
    for (int k = 0; k < 4; k++) begin
      stat_in = 7'($urandom);
      #1;
      chk(stat_o == {1'b0, stat_in}, "R8 passthrough", int'(stat_o), int'({1'b0, stat_in}));
    end

    // directed playback
    play(8'h05, 8'h00, 8'h00);
    play(8'hA3, 8'h01, 8'hEF);

    // R3 reload on re-enable while running
    cpu_wr(0, SEL_LEN, 8'h01);
    cpu_wr(0, SEL_CTRL, 8'h10);
    repeat (100) @(negedge clk_i);
    cpu_wr(0, SEL_CTRL, 8'h10);
    last = cyc;
    guard = 0;
    while (!mem_req_o && guard < 400) begin @(negedge clk_i); guard++; end
    chk(cyc - last == PER, "R3 timer reload", cyc - last, PER);
    guard = 0;
    while (!dac_we_o && guard < 10) begin @(negedge clk_i); guard++; end

    // R11 disable mid-playback
    begin
      bit seen = 0;
      cpu_wr(0, SEL_CTRL, 8'hEF & 8'($urandom));
      repeat (600) begin @(negedge clk_i); if (mem_req_o || irq_o) seen = 1; end
      chk(!seen, "R11 disable stops playback", int'(seen), 0);
    end

    // random rounds
    for (int r = 0; r < 4; r++)
      play(8'($urandom), 8'($urandom_range(0, 1)), 8'($urandom));

    // R7 wrap on fast instance
    cpu_wr(1, SEL_ADDR, 8'hFF);
    for (int r = 0; r < 5; r++) begin
      cpu_wr(1, SEL_LEN, 8'hFF);
      cpu_wr(1, SEL_CTRL, 8'h10);
      guard = 0;
      while (!f_irq && guard < 12000) begin @(negedge clk_i); guard++; end
      chk(f_irq, "R5 fast run end", int'(f_irq), 1);
    end
    chk(f_bad == 0, "R7 consecutive addresses", f_bad, 0);
    chk(f_wrap, "R7 wrap 7FFF to 0", int'(f_wrap), 1);
    chk(f_cnt == 5 * 4081, "R2 max length fetches", f_cnt, 5 * 4081);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule